// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs single read and write cycles on an external asynchronous memory bus. Each cycle can have one, two or three wait states. A client hands over one request at a time through a valid/ready handshake. The request carries the address, the write data, a write flag, a high-byte enable and, sampled at the same moment, the wait setting. The sequencer then drives the bus address, high-byte enable, chip select, address latch enable, read strobe, write strobe and data-drive enable. On a read it captures the returned data and presents it as a one-clock response.

Every bus edge must fall on a half period of the bus clock. For that reason the block runs on an internal clock at twice the bus rate and generates the bus clock itself. A half-period counter indexes each cycle, so every strobe edge sits at a fixed half index that depends only on the latched wait count w. In the requirements, "half k" means the k-th internal clock period of a cycle, counted from 0 at the period that starts on the accepting edge.

Top module: `ebus_cycle_seq`

## Requirements
- R1: During and right after synchronous reset: bus_cs_n, bus_rd_n and bus_wr_n are 1, bus_ale and bus_oe are 0, and rsp_valid is 0.
- R2: bus_clk toggles on every internal clock edge and is 0 after reset. Every cycle starts on a falling bus_clk edge, so bus_clk is 0 during half 0.
- R3: cfg_wait is latched when a request is accepted, and a later change has no effect on that cycle. A value of 0 gives w=1, and 1, 2 or 3 give w equal to that value. bus_cs_n is 0 for exactly 2w+2 halves (w+1 bus periods). bus_ale is 1 in half 0 only.
- R4: A read drives bus_rd_n to 0 for halves 1 through 2w+1, which is 3, 5 or 7 halves. bus_oe stays 0 for the whole read.
- R5: Read data is captured from bus_din on the edge at which bus_rd_n returns to 1. It appears on rsp_rdata with rsp_valid at 1 for exactly the following internal clock period.
- R6: A write drives bus_wr_n to 0 for halves 2 through 2w, which is 1, 3 or 5 halves. bus_rd_n stays 1 during a write.
- R7: A write sets bus_oe to 1 from half 1 to half 2w+1, with bus_dout equal to the request's write data. That gives 2w halves (w bus periods) before bus_wr_n rises, followed by exactly one further half.
- R8: req_ready is 1 only when no cycle is in progress and bus_clk is 1. It stays 0 from the accepting edge to the end of the trailing half. A request is accepted on an edge where req_valid and req_ready are both 1.
- R9: bus_addr equals the accepted address and bus_hi_n equals the inverse of the accepted high-byte enable. Both hold stable for every half of the cycle.
- R10: A write cycle never raises rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | WAIT_W | Wait-state setting, sampled on acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 for write, 0 for read |
| req_hi_en | input | 1 | High-byte enable |
| rsp_valid | output | 1 | Read data valid, one clock |
| rsp_rdata | output | DW | Captured read data |
| bus_clk | output | 1 | Generated bus clock |
| bus_addr | output | AW | Bus address |
| bus_hi_n | output | 1 | High-byte enable, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address latch enable pulse |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dout | output | DW | Data driven on writes |
| bus_oe | output | 1 | Data-drive enable |
| bus_din | input | DW | Data returned on reads |

## Verification
The bench builds the block with AW=12, DW=16 and the default WAIT_W=2. This lets every cfg_wait code, including the 0-means-1 case, reach the hardware, and the wait-dependent half counts can be compared for w=1, 2 and 3. The bench's bus model drives bus_din only while bus_rd_n is low, so a capture point placed one half late returns zero and is caught. Requests are issued back to back and cfg_wait is changed in mid-cycle. This exercises the ready gap, the alignment to bus_clk and the latching of the wait setting.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  // registered control pins of the bus
  typedef struct packed {
    logic ale;
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic oe;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0};
endpackage

// File: rtl/ebus_bclk_gen.sv
module ebus_bclk_gen (
  input  logic clk,
  input  logic rst,
  output logic bclk_o
);
  always_ff @(posedge clk) begin
    if (rst) bclk_o <= 1'b0;
    else     bclk_o <= ~bclk_o;
  end

  // R2: bus clock toggles every internal edge
  p_bclk_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bclk_o != $past(bclk_o)));
endmodule

// File: rtl/ebus_half_timer.sv
module ebus_half_timer #(
  parameter int WAIT_W = 2,
  localparam int PH_W = WAIT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_in,
  output logic              busy_q,
  output logic              last_q,
  output logic              busy_n,
  output logic [PH_W-1:0]   ph_n,
  output logic [WAIT_W-1:0] wt_n
);
  logic [PH_W-1:0]   ph_q;
  logic [WAIT_W-1:0] wt_q;
  logic [WAIT_W-1:0] wt_eff;

  assign wt_eff = (wait_in == '0) ? WAIT_W'(1) : wait_in;
  // final half of a cycle has index 2w+1
  assign last_q = busy_q && (ph_q == {wt_q, 1'b1});

  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    wt_n   = wt_q;
    if (start) begin
      busy_n = 1'b1;
      ph_n   = '0;
      wt_n   = wt_eff;
    end else if (busy_q) begin
      if (last_q) begin
        busy_n = 1'b0;
        ph_n   = '0;
      end else begin
        ph_n = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      wt_q   <= WAIT_W'(1);
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      wt_q   <= wt_n;
    end
  end

  // R3: no new start while a cycle runs; latched wait is never zero
  p_no_restart_r3: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !start);
  p_wait_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (wt_q != '0));
endmodule

// File: rtl/ebus_ctl_dec.sv
module ebus_ctl_dec
  import ebus_pkg::*;
#(
  parameter int WAIT_W = 2,
  localparam int PH_W = WAIT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_n,
  input  logic [PH_W-1:0]   ph_n,
  input  logic [WAIT_W-1:0] wt_n,
  input  logic              is_wr_n,
  output bus_ctl_t          ctl_q
);
  bus_ctl_t ctl_d;
  logic [PH_W-1:0] rd_last;
  logic [PH_W-1:0] wr_last;

  assign rd_last = {wt_n, 1'b1};   // 2w+1
  assign wr_last = {wt_n, 1'b0};   // 2w

  always_comb begin
    ctl_d      = CTL_IDLE;
    ctl_d.cs_n = ~busy_n;
    ctl_d.ale  = busy_n && (ph_n == '0);
    if (busy_n && !is_wr_n && ph_n >= PH_W'(1) && ph_n <= rd_last)
      ctl_d.rd_n = 1'b0;
    if (busy_n && is_wr_n && ph_n >= PH_W'(2) && ph_n <= wr_last)
      ctl_d.wr_n = 1'b0;
    ctl_d.oe   = busy_n && is_wr_n && (ph_n >= PH_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= CTL_IDLE;
    else     ctl_q <= ctl_d;
  end

  // strobe width counters for the checks below
  logic [WAIT_W-1:0] wt_d;
  logic [PH_W:0]     rd_run;
  logic [PH_W:0]     wr_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      wt_d   <= WAIT_W'(1);
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      wt_d   <= wt_n;
      rd_run <= ctl_q.rd_n ? '0 : rd_run + 1'b1;
      wr_run <= ctl_q.wr_n ? '0 : wr_run + 1'b1;
    end
  end

  // R4: read strobe lasts 2w+1 halves
  p_rd_width_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.rd_n) |-> (rd_run == {1'b0, wt_d, 1'b1}));
  // R6: write strobe lasts 2w-1 halves
  p_wr_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.wr_n) |-> (wr_run == ({1'b0, wt_d, 1'b0} - 1'b1)));
  // R7: drive ends one half after write strobe rises, together with select
  p_oe_tail_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q.oe) |-> ($past(ctl_q.wr_n) && $rose(ctl_q.cs_n)));
  // R4: never drive the bus during a read strobe
  p_no_conflict_r4: assert property (@(posedge clk) disable iff (rst)
    !(ctl_q.oe && !ctl_q.rd_n));
endmodule

// File: rtl/ebus_cycle_seq.sv
module ebus_cycle_seq
  import ebus_pkg::*;
#(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_write,
  input  logic              req_hi_en,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              bus_clk,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_hi_n,
  output logic              bus_cs_n,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_oe,
  input  logic [DW-1:0]     bus_din
);
  localparam int PH_W = WAIT_W + 1;

  logic              start;
  logic              busy_q, last_q, busy_n;
  logic [PH_W-1:0]   ph_n;
  logic [WAIT_W-1:0] wt_n;
  logic              wr_q, wr_n;
  bus_ctl_t          ctl_q;

  ebus_bclk_gen u_bclk (
    .clk    (clk),
    .rst    (rst),
    .bclk_o (bus_clk)
  );

  // accept only while the bus clock is high so half 0 begins on a falling edge
  assign req_ready = !busy_q && bus_clk;
  assign start     = req_valid && req_ready;
  assign wr_n      = start ? req_write : wr_q;

  ebus_half_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wait_in (cfg_wait),
    .busy_q  (busy_q),
    .last_q  (last_q),
    .busy_n  (busy_n),
    .ph_n    (ph_n),
    .wt_n    (wt_n)
  );

  ebus_ctl_dec #(.WAIT_W(WAIT_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .busy_n  (busy_n),
    .ph_n    (ph_n),
    .wt_n    (wt_n),
    .is_wr_n (wr_n),
    .ctl_q   (ctl_q)
  );

  assign bus_ale  = ctl_q.ale;
  assign bus_cs_n = ctl_q.cs_n;
  assign bus_rd_n = ctl_q.rd_n;
  assign bus_wr_n = ctl_q.wr_n;
  assign bus_oe   = ctl_q.oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      bus_addr <= '0;
      bus_hi_n <= 1'b1;
      bus_dout <= '0;
    end else if (start) begin
      wr_q     <= req_write;
      bus_addr <= req_addr;
      bus_hi_n <= ~req_hi_en;
      bus_dout <= req_wdata;
    end
  end

  // capture on the edge where the read strobe is released
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= last_q && !wr_q;
      if (last_q && !wr_q) rsp_rdata <= bus_din;
    end
  end

  // R8: ready only when the bus is deselected
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> bus_cs_n);
  // R2: ALE only in a selected half with the bus clock low
  p_ale_align_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (!bus_cs_n && !bus_clk));
  // R5: response follows the read strobe release
  p_rsp_after_rd_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($rose(bus_rd_n) && $past(bus_wr_n)));
  // R9: address holds while selected
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !bus_ale) |-> ($stable(bus_addr) && $stable(bus_hi_n)));
endmodule

// File: tb/ebus_cycle_seq_tb_top.sv
module ebus_cycle_seq_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int WAIT_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [AW-1:0]     req_addr = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic              req_write = 1'b0;
  logic              req_hi_en = 1'b0;
  logic              rsp_valid;
  logic [DW-1:0]     rsp_rdata;
  logic              bus_clk;
  logic [AW-1:0]     bus_addr;
  logic              bus_hi_n, bus_cs_n, bus_ale, bus_rd_n, bus_wr_n, bus_oe;
  logic [DW-1:0]     bus_dout;
  logic [DW-1:0]     bus_din;

  always #4 clk = ~clk;   // 125 MHz

  ebus_cycle_seq #(.AW(AW), .DW(DW), .WAIT_W(WAIT_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_hi_en(req_hi_en),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_hi_n(bus_hi_n),
    .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  function automatic logic [DW-1:0] mem_of(input logic [AW-1:0] a);
    return DW'(a) * 16'h9E37 ^ 16'h5A5A;
  endfunction

  // bus model: data valid only while the read strobe is low
  assign bus_din = bus_rd_n ? '0 : mem_of(bus_addr);

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          hi;
    logic [2:0]    w;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] rd_q[$];

  int n_chk = 0;
  int n_bad = 0;
  int n_reads = 0;
  int n_rsp = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit hi, input logic [WAIT_W-1:0] ws,
                       input logic [WAIT_W-1:0] ws_after);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    req_hi_en = hi; cfg_wait = ws;
    while (!req_ready) @(negedge clk);
    e.wr = wr; e.addr = a; e.data = d; e.hi = hi;
    e.w = (ws == 0) ? 3'd1 : 3'(ws);
    exp_q.push_back(e);
    if (!wr) begin
      rd_q.push_back(mem_of(a));
      n_reads++;
    end
    @(negedge clk);
    req_valid = 1'b0; cfg_wait = ws_after;  // R3: late change must not matter
  endtask

  // monitor / scoreboard
  bit   in_cyc = 0;
  int   idx, cs_cnt, ale_cnt, rd_cnt, rd_first, wr_cnt, wr_first, oe_cnt, oe_first;
  bit   bclk0, ale0, hi0, unstable, dout_bad, rdy_bad;
  logic [AW-1:0] addr0;
  logic clk_prev = 1'b1;
  int   clk_bad = 0;
  exp_t cur;

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_clk == clk_prev) clk_bad++;
      clk_prev = bus_clk;
      if (rsp_valid) begin
        n_rsp++;
        if (rd_q.size() == 0) chk(0, "R10 unexpected rsp", 1, 0);
        else begin
          logic [DW-1:0] ed;
          ed = rd_q.pop_front();
          chk(rsp_rdata == ed, "R5 read data", int'(rsp_rdata), int'(ed));
        end
      end
      if (!bus_cs_n) begin
        if (!in_cyc) begin
          in_cyc = 1; idx = 0; cs_cnt = 0; ale_cnt = 0;
          rd_cnt = 0; rd_first = -1; wr_cnt = 0; wr_first = -1;
          oe_cnt = 0; oe_first = -1;
          bclk0 = bus_clk; ale0 = bus_ale; addr0 = bus_addr; hi0 = bus_hi_n;
          unstable = 0; dout_bad = 0; rdy_bad = 0;
          if (exp_q.size() == 0) chk(0, "R8 cycle without request", 1, 0);
          else cur = exp_q[0];
        end
        cs_cnt++;
        if (bus_ale) ale_cnt++;
        if (!bus_rd_n) begin if (rd_first < 0) rd_first = idx; rd_cnt++; end
        if (!bus_wr_n) begin if (wr_first < 0) wr_first = idx; wr_cnt++; end
        if (bus_oe) begin
          if (oe_first < 0) oe_first = idx;
          oe_cnt++;
          if (bus_dout != cur.data) dout_bad = 1;
        end
        if (bus_addr != addr0 || bus_hi_n != hi0) unstable = 1;
        if (req_ready) rdy_bad = 1;
        idx++;
      end else if (in_cyc) begin
        int w;
        in_cyc = 0;
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        w = int'(cur.w);
        chk(cs_cnt == 2*w+2, "R3 select length", cs_cnt, 2*w+2);
        chk(ale_cnt == 1 && ale0, "R3 ALE in half 0 only", ale_cnt, 1);
        chk(bclk0 == 1'b0, "R2 start on falling bus clock", int'(bclk0), 0);
        chk(addr0 == cur.addr, "R9 address", int'(addr0), int'(cur.addr));
        chk(hi0 == ~cur.hi, "R9 high enable", int'(hi0), int'(~cur.hi));
        chk(!unstable, "R9 stable in cycle", int'(unstable), 0);
        chk(!rdy_bad, "R8 ready low in cycle", int'(rdy_bad), 0);
        if (!cur.wr) begin
          chk(rd_cnt == 2*w+1, "R4 read strobe halves", rd_cnt, 2*w+1);
          chk(rd_first == 1, "R4 read strobe start", rd_first, 1);
          chk(oe_cnt == 0, "R4 no drive in read", oe_cnt, 0);
        end else begin
          chk(wr_cnt == 2*w-1, "R6 write strobe halves", wr_cnt, 2*w-1);
          chk(wr_first == 2, "R6 write strobe start", wr_first, 2);
          chk(rd_cnt == 0, "R6 no read strobe", rd_cnt, 0);
          chk(oe_first == 1, "R7 drive start", oe_first, 1);
          chk(wr_first + wr_cnt - oe_first == 2*w, "R7 data lead",
              wr_first + wr_cnt - oe_first, 2*w);
          chk(oe_first + oe_cnt - (wr_first + wr_cnt) == 1, "R7 hold half",
              oe_first + oe_cnt - (wr_first + wr_cnt), 1);
          chk(!dout_bad, "R7 write data", int'(dout_bad), 0);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_cs_n && bus_rd_n && bus_wr_n, "R1 strobes idle in reset", 0, 0);
    chk(!bus_ale && !bus_oe && !rsp_valid, "R1 ale/oe/rsp low in reset", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_cs_n && bus_rd_n && bus_wr_n && !bus_oe && !rsp_valid,
        "R1 idle after reset", int'(bus_cs_n), 1);
    chk(bus_clk == 1'b1, "R2 bus clock after reset", int'(bus_clk), 1);

    issue(0, 12'h123, 16'h0000, 1, 2'd0, 2'd3);   // R3: 0 acts as 1
    issue(0, 12'h456, 16'h0000, 0, 2'd1, 2'd3);
    issue(0, 12'h789, 16'h0000, 1, 2'd2, 2'd1);
    issue(0, 12'hABC, 16'h0000, 0, 2'd3, 2'd1);
    issue(1, 12'h0F0, 16'hBEEF, 1, 2'd1, 2'd3);
    issue(1, 12'h00F, 16'h1234, 0, 2'd2, 2'd0);
    issue(1, 12'hFFF, 16'hA5C3, 1, 2'd3, 2'd1);
    issue(1, 12'h001, 16'h8001, 0, 2'd0, 2'd2);
    issue(0, 12'h002, 16'h0000, 1, 2'd3, 2'd0);
    issue(1, 12'h800, 16'h7FFE, 1, 2'd2, 2'd3);
    issue(0, 12'h3C3, 16'h0000, 0, 2'd1, 2'd2);

    while (exp_q.size() != 0 || in_cyc) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_rsp == n_reads, "R10 response count", n_rsp, n_reads);
    chk(rd_q.size() == 0, "R5 all reads answered", rd_q.size(), 0);
    chk(clk_bad == 0, "R2 bus clock toggles", clk_bad, 0);
    done = 1;
    finish_run();
  end
endmodule